// File: doc/BRIEF.md
# DMA Destination Address Generator

This block holds the destination address of one DMA channel and moves it after every transfer. A two-bit update mode picks one of three behaviours: the address stays put, it counts up, or it counts down. The step is one for byte transfers and two for word transfers. A separate configuration bit marks a destination that is an external device answering with an acknowledge strobe in single-address mode. While that bit is set, the address never moves, whatever the update mode says.

An optional repeat area confines the low address bits to a power-of-two window. The upper bits stay constant while the low bits wrap. When a step carries or borrows out of the window, the address still wraps to the other end. If the repeat interrupt is armed, that event also sets a sticky interrupt flag and clears the channel enable, so the channel stops. In block transfer mode the stop is postponed until the end-of-block pulse.

Setting the enable again resumes the channel from the exact address where it stopped. The interrupt request leaves the block only while the flag is set and the interrupt enable is 1. Software loads the configuration through a write strobe and may load the address only while the channel is disabled.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: Update mode codes are 2'b00 and 2'b01 for fixed, 2'b10 for increment and 2'b11 for decrement. The address changes only on a transfer strobe while the channel is enabled.
- R2: The step is 1 when the word select is 0 (byte) and 2 when it is 1 (word), in both the increment and the decrement mode.
- R3: While the external-destination bit is 1, a transfer leaves the address unchanged in every mode.
- R4: A repeat-size value k from 1 to ADDR_W-1 wraps the low k address bits inside a 2^k window and keeps the upper bits constant. A value of 0 means there is no repeat area, and the address then wraps at the full width.
- R5: Outside block mode, with the repeat interrupt enabled, a transfer that carries or borrows out of the window sets the flag and clears the enable at the same clock edge that stores the wrapped address.
- R6: The interrupt request is 1 exactly when the flag is 1 and the interrupt-enable input is 1.
- R7: In block mode, a window overflow does not stop the channel at once. The flag is set and the enable is cleared on the first end-of-block pulse that comes while the channel is enabled after the overflow.
- R8: After a repeat stop, setting the enable lets the next transfer continue from the address held when the channel stopped.
- R9: With the repeat size at 0, or with the repeat interrupt disabled, an overflow neither sets the flag nor clears the enable.
- R10: The flag is sticky. It stays set through re-enabling and transfers, and only the flag-clear input clears it.
- R11: An address write loads the address only while the enable is 0. While the channel is enabled the write is ignored.
- R12: Reset clears the update mode, the repeat interrupt enable, the flag, the enable and the address. After reset a transfer cannot move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Loads all configuration fields |
| cfg_mode_i | input | 2 | Update mode: 0x fixed, 10 increment, 11 decrement |
| cfg_word_i | input | 1 | 1 = word transfer (step 2), 0 = byte (step 1) |
| cfg_ext_dst_i | input | 1 | Destination is an acknowledging external device; address held |
| cfg_rpt_size_i | input | SZ_W | Repeat window as log2 of its size; 0 = no repeat area |
| cfg_rpt_ie_i | input | 1 | Repeat interrupt enable (stop on overflow) |
| cfg_blk_i | input | 1 | Block transfer mode: stop deferred to end of block |
| en_set_i | input | 1 | Sets the channel enable |
| en_clr_i | input | 1 | Clears the channel enable |
| addr_wr_i | input | 1 | Address write strobe, effective only while disabled |
| addr_wdata_i | input | ADDR_W | Address write value |
| xfer_i | input | 1 | One pulse per completed transfer |
| blk_end_i | input | 1 | End of a block-size transfer |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| addr_o | output | ADDR_W | Current destination address |
| en_o | output | 1 | Channel enable |
| flag_o | output | 1 | Repeat interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the configuration does not change while a block overflow is pending. They also assume that a stop and a set of the enable do not arrive in the same cycle. The block resolves that collision in favour of the stop, and a property on the enable would otherwise need to know the order. The bench rewrites the configuration only after it has cleared the enable. It pulses the enable set only in cycles with no transfer and no end of block, so every stimulus keeps to those assumptions.

// File: rtl/dda_pkg.sv
// Package: shared encodings for the destination address generator.
// Assumes: update mode is a two-bit field; bit 1 selects movement.
package dda_pkg;
    typedef enum logic [1:0] {
        UPD_FIX_A = 2'b00,
        UPD_FIX_B = 2'b01,
        UPD_INC   = 2'b10,
        UPD_DEC   = 2'b11
    } upd_mode_e;
endpackage

// File: rtl/dda_step.sv
// Module: dda_step
// Computes the next address for one transfer and flags a carry or
// borrow out of the repeat window. Purely combinational.
// Assumes: rpt_size_i == 0 means no window; values >= ADDR_W cover
// the whole address.
module dda_step #(
    parameter int ADDR_W = 16,
    parameter int SZ_W   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic              word_i,
    input  logic              ext_i,
    input  logic [SZ_W-1:0]   rpt_size_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              ovf_o
);
    import dda_pkg::*;

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] low;
    logic [ADDR_W-1:0] moved;
    logic [ADDR_W:0]   low_sum;
    logic              area_on;
    logic              active;
    logic              dec;

    assign area_on = (rpt_size_i != '0);

    // Window mask: one bit per address bit below the repeat size.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign mask[i] = !area_on || (32'(rpt_size_i) > i);
    end

    assign step    = word_i ? ADDR_W'(2) : ADDR_W'(1);
    assign active  = !ext_i && mode_i[1];
    assign dec     = (upd_mode_e'(mode_i) == UPD_DEC);
    assign low     = addr_i & mask;
    assign low_sum = {1'b0, low} + {1'b0, step};

    // Move the whole address, then keep the upper bits from the old value.
    always_comb begin
        moved  = dec ? (addr_i - step) : (addr_i + step);
        next_o = active ? ((addr_i & ~mask) | (moved & mask)) : addr_i;
        ovf_o  = active && area_on &&
                 (dec ? (low < step) : (low_sum > {1'b0, mask}));
    end
endmodule

// File: rtl/dda_ctrl.sv
// Module: dda_ctrl
// Owns the channel enable, the sticky flag and the pending block stop.
// Assumes: hit_i is an overflow seen on an accepted transfer.
module dda_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic rie_i,
    input  logic area_on_i,
    input  logic blk_i,
    input  logic blk_end_i,
    input  logic cfg_wr_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic flag_clr_i,
    output logic en_o,
    output logic flag_o
);
    logic armed;
    logic pend_q;
    logic stop_now;

    assign armed    = rie_i && area_on_i;
    assign stop_now = armed && (blk_i ? (blk_end_i && en_o && (pend_q || hit_i))
                                      : hit_i);

    // Channel enable: a stop wins over a set, a set over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_o <= 1'b0;
        else if (stop_now) en_o <= 1'b0;
        else if (en_set_i) en_o <= 1'b1;
        else if (en_clr_i) en_o <= 1'b0;
    end

    // Sticky flag: set by a stop, cleared only on request.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (stop_now)   flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
    end

    // Overflow seen in block mode, waiting for the block to end.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pend_q <= 1'b0;
        else if (stop_now || cfg_wr_i)          pend_q <= 1'b0;
        else if (hit_i && blk_i && armed)       pend_q <= 1'b1;
    end
endmodule

// File: rtl/dma_dst_addr_gen.sv
// Module: dma_dst_addr_gen (top)
// Destination address register of one DMA channel with fixed, up or
// down update, a power-of-two repeat window and a repeat-stop interrupt.
// Assumes: one xfer_i pulse per completed transfer; software writes
// the address only while the channel is disabled.
module dma_dst_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic              cfg_word_i,
    input  logic              cfg_ext_dst_i,
    input  logic [SZ_W-1:0]   cfg_rpt_size_i,
    input  logic              cfg_rpt_ie_i,
    input  logic              cfg_blk_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              xfer_i,
    input  logic              blk_end_i,
    input  logic              irq_en_i,
    input  logic              flag_clr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              en_o,
    output logic              flag_o,
    output logic              irq_o
);
    logic [1:0]        mode_q;
    logic              word_q;
    logic              ext_q;
    logic [SZ_W-1:0]   rsz_q;
    logic              rie_q;
    logic              blk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] next_addr;
    logic              ovf;
    logic              xfer_ok;

    assign xfer_ok = xfer_i && en_o;

    // Configuration register, loaded as a whole by cfg_wr_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            word_q <= 1'b0;
            ext_q  <= 1'b0;
            rsz_q  <= '0;
            rie_q  <= 1'b0;
            blk_q  <= 1'b0;
        end else if (cfg_wr_i) begin
            mode_q <= cfg_mode_i;
            word_q <= cfg_word_i;
            ext_q  <= cfg_ext_dst_i;
            rsz_q  <= cfg_rpt_size_i;
            rie_q  <= cfg_rpt_ie_i;
            blk_q  <= cfg_blk_i;
        end
    end

    dda_step #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) step_i (
        .addr_i     (addr_q),
        .mode_i     (mode_q),
        .word_i     (word_q),
        .ext_i      (ext_q),
        .rpt_size_i (rsz_q),
        .next_o     (next_addr),
        .ovf_o      (ovf)
    );

    dda_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (xfer_ok && ovf),
        .rie_i      (rie_q),
        .area_on_i  (rsz_q != '0),
        .blk_i      (blk_q),
        .blk_end_i  (blk_end_i),
        .cfg_wr_i   (cfg_wr_i),
        .en_set_i   (en_set_i),
        .en_clr_i   (en_clr_i),
        .flag_clr_i (flag_clr_i),
        .en_o       (en_o),
        .flag_o     (flag_o)
    );

    // Address register: a transfer updates it, a write loads it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr_q <= '0;
        else if (xfer_ok)            addr_q <= next_addr;
        else if (addr_wr_i && !en_o) addr_q <= addr_wdata_i;
    end

    assign addr_o = addr_q;
    assign irq_o  = flag_o && irq_en_i;
endmodule

// File: rtl/dda_checker.sv
// Module: dda_checker
// Temporal properties of the destination address generator, bound
// to the top. Assumes a stable configuration while a block stop is pending.
module dda_checker #(
    parameter int ADDR_W = 16,
    parameter int SZ_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_i,
    input logic              addr_wr_i,
    input logic              blk_end_i,
    input logic [1:0]        mode_q,
    input logic              word_q,
    input logic              ext_q,
    input logic [SZ_W-1:0]   rsz_q,
    input logic              blk_q,
    input logic [ADDR_W-1:0] addr_o,
    input logic              en_o,
    input logic              flag_o,
    input logic              irq_o
);
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && xfer_i && !mode_q[1]) |=> $stable(addr_o)); // R1

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && xfer_i && mode_q == 2'b10 && !ext_q && rsz_q == '0)
        |=> addr_o == $past(addr_o) + (($past(word_q)) ? ADDR_W'(2) : ADDR_W'(1))); // R2

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && xfer_i && ext_q) |=> $stable(addr_o)); // R3

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> !en_o); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R6

    AST_BLK_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && !blk_end_i) |=> !$rose(flag_o)); // R7

    AST_NO_AREA_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsz_q == '0 && !blk_q) |=> !$rose(flag_o)); // R9

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && addr_wr_i && !xfer_i) |=> $stable(addr_o)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !addr_wr_i) |=> $stable(addr_o)); // R1
endmodule

bind dma_dst_addr_gen dda_checker #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_i    (xfer_i),
    .addr_wr_i (addr_wr_i),
    .blk_end_i (blk_end_i),
    .mode_q    (mode_q),
    .word_q    (word_q),
    .ext_q     (ext_q),
    .rsz_q     (rsz_q),
    .blk_q     (blk_q),
    .addr_o    (addr_o),
    .en_o      (en_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/dma_dst_addr_gen_tb_top.sv
// Bench: a vector table of single-transfer cases, then directed tests.
// Inputs change on falling edges; outputs are sampled on falling edges.
module dma_dst_addr_gen_tb_top;
    localparam int ADDR_W = 16;
    localparam int SZ_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_i = 0, cfg_word_i = 0, cfg_ext_dst_i = 0;
    logic              cfg_rpt_ie_i = 0, cfg_blk_i = 0;
    logic [1:0]        cfg_mode_i = '0;
    logic [SZ_W-1:0]   cfg_rpt_size_i = '0;
    logic              en_set_i = 0, en_clr_i = 0, addr_wr_i = 0;
    logic [ADDR_W-1:0] addr_wdata_i = '0;
    logic              xfer_i = 0, blk_end_i = 0, irq_en_i = 0, flag_clr_i = 0;
    logic [ADDR_W-1:0] addr_o;
    logic              en_o, flag_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk; // 125 MHz

    dma_dst_addr_gen #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) dut_i (.*);

    // {mode[40:39], word[38], ext[37], size[36:33], start[32:17], expect[16:1], flag[0]}
    localparam int NV = 12;
    localparam logic [40:0] VEC [NV] = '{
        {2'b00, 1'b0, 1'b0, 4'd0, 16'h1234, 16'h1234, 1'b0}, // R1 fixed
        {2'b01, 1'b1, 1'b0, 4'd0, 16'h1234, 16'h1234, 1'b0}, // R1 fixed
        {2'b10, 1'b0, 1'b0, 4'd0, 16'h1234, 16'h1235, 1'b0}, // R2 inc byte
        {2'b10, 1'b1, 1'b0, 4'd0, 16'h1234, 16'h1236, 1'b0}, // R2 inc word
        {2'b11, 1'b0, 1'b0, 4'd0, 16'h1234, 16'h1233, 1'b0}, // R2 dec byte
        {2'b11, 1'b1, 1'b0, 4'd0, 16'h1234, 16'h1232, 1'b0}, // R2 dec word
        {2'b10, 1'b1, 1'b1, 4'd0, 16'h1234, 16'h1234, 1'b0}, // R3 ext hold
        {2'b10, 1'b0, 1'b0, 4'd4, 16'h123F, 16'h1230, 1'b1}, // R4 R5 carry
        {2'b11, 1'b1, 1'b0, 4'd4, 16'h1231, 16'h123F, 1'b1}, // R4 R5 borrow
        {2'b10, 1'b1, 1'b0, 4'd4, 16'h123D, 16'h123F, 1'b0}, // R4 no edge
        {2'b10, 1'b0, 1'b0, 4'd0, 16'hFFFF, 16'h0000, 1'b0}, // R9 no area
        {2'b11, 1'b0, 1'b0, 4'd8, 16'h5500, 16'h55FF, 1'b1}  // R4 R5 k=8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cfg_wr_i = 0; en_set_i = 0; en_clr_i = 0; addr_wr_i = 0;
        xfer_i = 0; blk_end_i = 0; flag_clr_i = 0;
    endtask

    task automatic setup(input logic [1:0] m, input logic w, input logic x,
                         input logic [SZ_W-1:0] k, input logic ie, input logic b,
                         input logic [ADDR_W-1:0] a);
        cfg_wr_i = 1; cfg_mode_i = m; cfg_word_i = w; cfg_ext_dst_i = x;
        cfg_rpt_size_i = k; cfg_rpt_ie_i = ie; cfg_blk_i = b;
        en_clr_i = 1; flag_clr_i = 1;
        cyc();
        addr_wr_i = 1; addr_wdata_i = a;
        cyc();
        en_set_i = 1;
        cyc();
    endtask

    task automatic xfer();
        xfer_i = 1;
        cyc();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R12 reset state
        chk("R12 addr", 32'(addr_o), 0);
        chk("R12 en", 32'(en_o), 0);
        chk("R12 flag", 32'(flag_o), 0);
        chk("R12 irq", 32'(irq_o), 0);
        en_set_i = 1; cyc();
        xfer(); xfer();
        chk("R12 mode reset fixed", 32'(addr_o), 0);

        // Vector table: one transfer per entry
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][40:39], VEC[v][38], VEC[v][37], VEC[v][36:33], 1'b1, 1'b0,
                  VEC[v][32:17]);
            xfer();
            chk($sformatf("R1/R2/R4 vec%0d addr", v), 32'(addr_o), 32'(VEC[v][16:1]));
            chk($sformatf("R5 vec%0d flag", v), 32'(flag_o), 32'(VEC[v][0]));
            chk($sformatf("R5 vec%0d en", v), 32'(en_o), 32'(!VEC[v][0]));
        end

        // R6 interrupt gating with the flag set by the last vector
        irq_en_i = 0; cyc();
        chk("R6 irq masked", 32'(irq_o), 0);
        irq_en_i = 1; cyc();
        chk("R6 irq raised", 32'(irq_o), 1);

        // R8 resume and R10 sticky flag
        setup(2'b10, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 16'h123F);
        xfer();
        chk("R5 stop en", 32'(en_o), 0);
        xfer();
        chk("R8 stopped holds", 32'(addr_o), 32'h1230);
        en_set_i = 1; cyc();
        xfer();
        chk("R8 resume addr", 32'(addr_o), 32'h1231);
        chk("R10 flag sticky", 32'(flag_o), 1);
        chk("R8 en after resume", 32'(en_o), 1);
        flag_clr_i = 1; cyc();
        chk("R10 flag cleared", 32'(flag_o), 0);
        chk("R6 irq follows flag", 32'(irq_o), 0);

        // R9 repeat interrupt disabled: wrap without stop
        setup(2'b10, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 16'h123F);
        xfer();
        chk("R9 wrap addr", 32'(addr_o), 32'h1230);
        chk("R9 no flag", 32'(flag_o), 0);
        chk("R9 en kept", 32'(en_o), 1);

        // R11 write ignored while enabled
        addr_wr_i = 1; addr_wdata_i = 16'hAAAA; cyc();
        chk("R11 write ignored", 32'(addr_o), 32'h1230);

        // R7 block mode defers the stop
        setup(2'b10, 1'b0, 1'b0, 4'd4, 1'b1, 1'b1, 16'h123F);
        xfer();
        chk("R7 wrapped addr", 32'(addr_o), 32'h1230);
        chk("R7 no flag yet", 32'(flag_o), 0);
        chk("R7 en still on", 32'(en_o), 1);
        xfer();
        chk("R7 continues", 32'(addr_o), 32'h1231);
        blk_end_i = 1; cyc();
        chk("R7 flag at block end", 32'(flag_o), 1);
        chk("R7 en cleared at block end", 32'(en_o), 0);
        chk("R7 addr held", 32'(addr_o), 32'h1231);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule